// File: doc/BRIEF.md
# Narrow-Bus Register Access Bridge

The bridge lets a 32-bit CPU register port reach slave registers that sit behind a narrow, multi-cycle register bus. Each slave register is 8 bits wide. The slave bus carries 8 bits toward the slave and returns only 4 bits per transaction. So one CPU access becomes a series of slave transactions that the bridge orders itself. A 32-bit read, for example, takes eight nibble reads.

On the CPU side, reads can be 1, 2 or 4 bytes wide. Direct writes can be 1, 2 or 4 bytes wide and come in three kinds: plain, bit-set and bit-clear. Masked writes can be one nibble, one byte or two bytes wide. Set, clear and masked writes let software change single fields without a read-modify-write.

A write is either posted or non-posted. A posted write is acknowledged as soon as it sits in a small in-order queue. A non-posted write holds the CPU until its slave transactions have finished. A read always waits until every queued write ahead of it, and its own nibble reads, are complete.

Top module: `nbus_bridge`

## Requirements
- R1: While reset is asserted, and after it is released with no request pending, `cpu_ready_o` is low, `sl_sel_o` is low, `sl_wdata_o` is zero and `cpu_rdata_o` is zero.
- R2: Every slave transaction lasts exactly three consecutive cycles with `sl_sel_o` high. `sl_phase_o` is 0 (address), then 1 (data), then 2 (strobe). `sl_addr_o` and `sl_op_o` stay unchanged across the three cycles. `sl_wdata_o` is non-zero only in the data phase. The slave acts at the clock edge that ends the strobe cycle, and `sl_rdata_i` is sampled at that same edge.
- R3: `cpu_size_i` selects the width of a read: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. Each byte k, counting up from `cpu_addr_i`, is read at address base+k. Bits 3:0 are read first (slave op 0) and bits 7:4 second (slave op 1). The result is packed into `cpu_rdata_o` least significant nibble first, and all bits above the read width are zero.
- R4: A direct write has `cpu_op_i` 0 (plain), 1 (set) or 2 (clear), and uses the same byte widths as a read. It issues one transaction per byte. Byte k of `cpu_wdata_i` goes to address base+k with slave op 2 (replace), 3 (OR in) or 4 (clear the bits that are 1).
- R5: A masked write has `cpu_op_i` 3. Its mask is in `cpu_wdata_i[31:16]` and its data in `cpu_wdata_i[15:0]`. The width is set by `cpu_size_i`:
  - 0 updates bits 3:0 of the base register;
  - 3 updates bits 7:4 of the base register;
  - 1 updates both nibbles of the base register;
  - 2 updates both nibbles of the base register and of base+1.

  Nibble j of the mask and data forms one transaction. That transaction carries `{mask, data}` on `sl_wdata_o` with slave op 5 (low half) or 6 (high half). Only bits whose mask bit is 1 change.
- R6: A posted write (`cpu_we_i` and `cpu_posted_i` both high) is acknowledged in the same cycle it is presented, as long as the queue has a free slot.
- R7: The write queue holds QDEPTH entries (4 by default). While it is full, a posted write sees `cpu_ready_o` low. That write is acknowledged in the cycle after the engine takes the queue head.
- R8: A non-posted write is acknowledged only after all of its slave transactions have completed. Starting from an idle bridge, and with T transactions, `cpu_ready_o` rises 2+3T cycles after the request cycle.
- R9: A read completes only after every earlier posted write has reached the slave, and the data it returns reflects those writes.
- R10: Starting from an idle bridge, a read of 1, 2 or 4 bytes raises `cpu_ready_o` 8, 14 or 26 cycles after the request cycle, together with valid data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU access request, held until acknowledged |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_posted_i | input | 1 | Write is posted (acknowledged once queued) |
| cpu_op_i | input | 2 | 0 plain, 1 set, 2 clear, 3 masked |
| cpu_size_i | input | 2 | Width code (see R3, R5) |
| cpu_addr_i | input | AW | Base slave register address |
| cpu_wdata_i | input | 32 | Write data, or mask and data for masked writes |
| cpu_ready_o | output | 1 | Access acknowledged this cycle |
| cpu_rdata_o | output | 32 | Read result, valid with `cpu_ready_o` on a read |
| sl_sel_o | output | 1 | Slave transaction in progress |
| sl_phase_o | output | 2 | 0 address, 1 data, 2 strobe |
| sl_addr_o | output | AW | Slave register address |
| sl_op_o | output | 3 | Slave op code (see R3 to R5) |
| sl_wdata_o | output | 8 | Slave write byte, data phase only |
| sl_rdata_i | input | 4 | Slave read nibble, sampled at end of strobe |

## Verification
A posted write with room in the queue is due in the request cycle itself. Every blocking access that starts from an idle bridge is due exactly 2+3T cycles after its request cycle: one cycle to enter the queue, one to be taken by the engine, and three per transaction. The bench therefore waits for the slave bus to be idle before each blocking vector. It then counts cycles at mid-period, one time step after the falling edge, and counts the strobe cycles between request and acknowledge. The queue-full case is timed from a known sequence of back-to-back posted writes, which makes the stall exactly ten cycles.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
  localparam int unsigned CPU_DW  = 32;
  localparam int unsigned SL_WW   = 8;
  localparam int unsigned SL_RW   = 4;
  localparam int unsigned MAX_TXN = (CPU_DW / SL_WW) * (SL_WW / SL_RW);

  typedef enum logic [1:0] {
    CO_WR  = 2'd0,
    CO_SET = 2'd1,
    CO_CLR = 2'd2,
    CO_MSK = 2'd3
  } cpu_op_e;

  typedef enum logic [2:0] {
    SO_RDL = 3'd0,
    SO_RDH = 3'd1,
    SO_WR  = 3'd2,
    SO_SET = 3'd3,
    SO_CLR = 3'd4,
    SO_MLO = 3'd5,
    SO_MHI = 3'd6
  } sl_op_e;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_DATA = 2'd1,
    PH_STB  = 2'd2
  } phase_e;
endpackage

// File: rtl/nbb_fifo.sv
module nbb_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/nbb_front.sv
module nbb_front (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  input  logic posted_i,
  input  logic full_i,
  input  logic empty_i,
  input  logic busy_i,
  output logic push_o,
  output logic ready_o
);
  logic pushed_q;
  logic is_posted;

  assign is_posted = we_i & posted_i;
  // a blocking access enters the queue once, then waits for the queue to drain
  assign push_o  = req_i & ~full_i & ~pushed_q;
  assign ready_o = req_i & (is_posted ? ~full_i : (pushed_q & empty_i & ~busy_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pushed_q <= 1'b0;
    else if (ready_o)               pushed_q <= 1'b0;
    else if (push_o && !is_posted)  pushed_q <= 1'b1;
  end

  assert_wait_queued_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !is_posted) |-> $past(push_o || pushed_q));
endmodule

// File: rtl/nbb_seq.sv
module nbb_seq
  import nbb_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          empty_i,
  input  logic          cmd_rd_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [1:0]    cmd_size_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [31:0]   cmd_wdata_i,
  output logic          pop_o,
  output logic          busy_o,
  output logic [31:0]   rdata_o,
  output logic          sl_sel_o,
  output logic [1:0]    sl_phase_o,
  output logic [AW-1:0] sl_addr_o,
  output logic [2:0]    sl_op_o,
  output logic [7:0]    sl_wdata_o,
  input  logic [3:0]    sl_rdata_i
);
  localparam int unsigned KW = $clog2(MAX_TXN);

  logic              busy_q, rd_q;
  logic [1:0]        op_q, size_q;
  logic [AW-1:0]     addr_q;
  logic [CPU_DW-1:0] wdata_q, rdata_q;
  logic [KW-1:0]     k_q, last_q;
  phase_e            phase_q;

  logic [KW:0]       nib_c;
  logic [KW-1:0]     off_c;
  sl_op_e            op_c;
  logic [7:0]        byte_c;

  function automatic logic [KW-1:0] last_of(input logic rd, input logic [1:0] op,
                                            input logic [1:0] sz);
    logic [KW-1:0] nb1;
    case (sz)
      2'd0:    nb1 = KW'(0);
      2'd1:    nb1 = KW'(1);
      default: nb1 = KW'(3);
    endcase
    if (rd) return KW'({nb1, 1'b1});
    if (op == CO_MSK) begin
      case (sz)
        2'd1:    return KW'(1);
        2'd2:    return KW'(3);
        default: return KW'(0);
      endcase
    end
    return nb1;
  endfunction

  always_comb begin
    nib_c  = {1'b0, k_q} + {{KW{1'b0}}, (size_q == 2'd3)};
    off_c  = '0;
    op_c   = SO_RDL;
    byte_c = '0;
    if (rd_q) begin
      off_c = k_q >> 1;
      op_c  = k_q[0] ? SO_RDH : SO_RDL;
    end else if (op_q == CO_MSK) begin
      off_c  = KW'(nib_c >> 1);
      op_c   = nib_c[0] ? SO_MHI : SO_MLO;
      byte_c = {4'(wdata_q >> (16 + 4 * k_q)), 4'(wdata_q >> (4 * k_q))};
    end else begin
      off_c  = k_q;
      byte_c = 8'(wdata_q >> (8 * k_q));
      case (op_q)
        CO_SET:  op_c = SO_SET;
        CO_CLR:  op_c = SO_CLR;
        default: op_c = SO_WR;
      endcase
    end
  end

  assign pop_o      = ~busy_q & ~empty_i;
  assign busy_o     = busy_q;
  assign rdata_o    = rdata_q;
  assign sl_sel_o   = busy_q;
  assign sl_phase_o = busy_q ? phase_q : PH_ADDR;
  assign sl_addr_o  = busy_q ? addr_q + AW'(off_c) : '0;
  assign sl_op_o    = busy_q ? op_c : SO_RDL;
  assign sl_wdata_o = (busy_q && phase_q == PH_DATA) ? byte_c : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      op_q    <= '0;
      size_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      k_q     <= '0;
      last_q  <= '0;
      phase_q <= PH_ADDR;
    end else if (!busy_q) begin
      if (!empty_i) begin
        busy_q  <= 1'b1;
        rd_q    <= cmd_rd_i;
        op_q    <= cmd_op_i;
        size_q  <= cmd_size_i;
        addr_q  <= cmd_addr_i;
        wdata_q <= cmd_wdata_i;
        k_q     <= '0;
        last_q  <= last_of(cmd_rd_i, cmd_op_i, cmd_size_i);
        phase_q <= PH_ADDR;
        if (cmd_rd_i) rdata_q <= '0;
      end
    end else begin
      case (phase_q)
        PH_ADDR: phase_q <= PH_DATA;
        PH_DATA: phase_q <= PH_STB;
        default: begin
          phase_q <= PH_ADDR;
          if (rd_q) rdata_q <= rdata_q | (CPU_DW'(sl_rdata_i) << (4 * k_q));
          if (k_q == last_q) busy_q <= 1'b0;
          else               k_q    <= k_q + KW'(1);
        end
      endcase
    end
  end

  assert_addr_to_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sl_sel_o && sl_phase_o == PH_ADDR) |=> (sl_sel_o && sl_phase_o == PH_DATA));
  assert_data_to_stb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sl_sel_o && sl_phase_o == PH_DATA) |=> (sl_sel_o && sl_phase_o == PH_STB));
  assert_addr_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sl_sel_o && sl_phase_o != PH_ADDR) |-> ($stable(sl_addr_o) && $stable(sl_op_o)));
endmodule

// File: rtl/nbus_bridge.sv
module nbus_bridge
  import nbb_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter int unsigned QDEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic          cpu_posted_i,
  input  logic [1:0]    cpu_op_i,
  input  logic [1:0]    cpu_size_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [31:0]   cpu_wdata_i,
  output logic          cpu_ready_o,
  output logic [31:0]   cpu_rdata_o,
  output logic          sl_sel_o,
  output logic [1:0]    sl_phase_o,
  output logic [AW-1:0] sl_addr_o,
  output logic [2:0]    sl_op_o,
  output logic [7:0]    sl_wdata_o,
  input  logic [3:0]    sl_rdata_i
);
  localparam int unsigned EW = 1 + 2 + 2 + AW + CPU_DW;

  logic          push, pop, full, empty, busy;
  logic [EW-1:0] q_in, q_out;
  logic          h_rd;
  logic [1:0]    h_op, h_size;
  logic [AW-1:0] h_addr;
  logic [31:0]   h_wdata;

  assign q_in = {~cpu_we_i, cpu_op_i, cpu_size_i, cpu_addr_i, cpu_wdata_i};
  assign {h_rd, h_op, h_size, h_addr, h_wdata} = q_out;

  nbb_front u_front (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (cpu_req_i),
    .we_i     (cpu_we_i),
    .posted_i (cpu_posted_i),
    .full_i   (full),
    .empty_i  (empty),
    .busy_i   (busy),
    .push_o   (push),
    .ready_o  (cpu_ready_o)
  );

  nbb_fifo #(.WIDTH(EW), .DEPTH(QDEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   (q_in),
    .pop_i   (pop),
    .dout_o  (q_out),
    .full_o  (full),
    .empty_o (empty)
  );

  nbb_seq #(.AW(AW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .empty_i     (empty),
    .cmd_rd_i    (h_rd),
    .cmd_op_i    (h_op),
    .cmd_size_i  (h_size),
    .cmd_addr_i  (h_addr),
    .cmd_wdata_i (h_wdata),
    .pop_o       (pop),
    .busy_o      (busy),
    .rdata_o     (cpu_rdata_o),
    .sl_sel_o    (sl_sel_o),
    .sl_phase_o  (sl_phase_o),
    .sl_addr_o   (sl_addr_o),
    .sl_op_o     (sl_op_o),
    .sl_wdata_o  (sl_wdata_o),
    .sl_rdata_i  (sl_rdata_i)
  );

  assert_blocking_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ready_o && !(cpu_we_i && cpu_posted_i)) |-> !sl_sel_o);
endmodule

// File: tb/sim_nbus_bridge.sv
module sim_nbus_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NV = 16;

  typedef struct packed {
    logic        we;
    logic        posted;
    logic [1:0]  op;
    logic [1:0]  size;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [7:0]  lat;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 2'd0, 2'd2, 8'h10, 32'hA5C3_1E7F, 8'd14},
    '{1'b0, 1'b0, 2'd0, 2'd2, 8'h10, 32'h0,         8'd26},
    '{1'b1, 1'b0, 2'd1, 2'd1, 8'h10, 32'h0000_8001, 8'd8},
    '{1'b1, 1'b0, 2'd2, 2'd0, 8'h11, 32'h0000_00F0, 8'd5},
    '{1'b0, 1'b0, 2'd0, 2'd1, 8'h10, 32'h0,         8'd14},
    '{1'b1, 1'b0, 2'd3, 2'd0, 8'h12, 32'h000F_0005, 8'd5},
    '{1'b1, 1'b0, 2'd3, 2'd3, 8'h12, 32'h000C_0008, 8'd5},
    '{1'b0, 1'b0, 2'd0, 2'd0, 8'h12, 32'h0,         8'd8},
    '{1'b1, 1'b0, 2'd3, 2'd2, 8'h14, 32'hF0F0_1234, 8'd14},
    '{1'b1, 1'b1, 2'd0, 2'd2, 8'h20, 32'hDEAD_BEEF, 8'd0},
    '{1'b1, 1'b1, 2'd1, 2'd0, 8'h20, 32'h0000_0010, 8'd0},
    '{1'b0, 1'b0, 2'd0, 2'd2, 8'h20, 32'h0,         8'd26},
    '{1'b1, 1'b0, 2'd3, 2'd1, 8'h13, 32'h00FF_00A5, 8'd8},
    '{1'b0, 1'b0, 2'd0, 2'd2, 8'h12, 32'h0,         8'd26},
    '{1'b1, 1'b1, 2'd2, 2'd1, 8'h20, 32'h0000_FFFF, 8'd0},
    '{1'b0, 1'b0, 2'd0, 2'd1, 8'h21, 32'h0,         8'd14}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req, cpu_we, cpu_posted;
  logic [1:0]    cpu_op, cpu_size;
  logic [AW-1:0] cpu_addr;
  logic [31:0]   cpu_wdata;
  logic          cpu_ready;
  logic [31:0]   cpu_rdata;
  logic          sl_sel;
  logic [1:0]    sl_phase;
  logic [AW-1:0] sl_addr;
  logic [2:0]    sl_op;
  logic [7:0]    sl_wdata;
  logic [3:0]    sl_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int stb_cnt = 0;
  int proto_err = 0;
  logic [1:0] prev_phase;
  logic       prev_sel;

  logic [7:0] slv_mem [256];
  logic [7:0] ref_mem [256];
  logic [7:0] slv_wlat;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nbus_bridge #(.AW(AW), .QDEPTH(4)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cpu_req_i    (cpu_req),
    .cpu_we_i     (cpu_we),
    .cpu_posted_i (cpu_posted),
    .cpu_op_i     (cpu_op),
    .cpu_size_i   (cpu_size),
    .cpu_addr_i   (cpu_addr),
    .cpu_wdata_i  (cpu_wdata),
    .cpu_ready_o  (cpu_ready),
    .cpu_rdata_o  (cpu_rdata),
    .sl_sel_o     (sl_sel),
    .sl_phase_o   (sl_phase),
    .sl_addr_o    (sl_addr),
    .sl_op_o      (sl_op),
    .sl_wdata_o   (sl_wdata),
    .sl_rdata_i   (sl_rdata)
  );

  // slave register model, driven purely by the slave-bus op codes
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) slv_mem[i] <= 8'h00;
      slv_wlat <= 8'h00;
    end else if (sl_sel) begin
      if (sl_phase == 2'd1) slv_wlat <= sl_wdata;
      if (sl_phase == 2'd2) begin
        case (sl_op)
          3'd2: slv_mem[sl_addr] <= slv_wlat;
          3'd3: slv_mem[sl_addr] <= slv_mem[sl_addr] | slv_wlat;
          3'd4: slv_mem[sl_addr] <= slv_mem[sl_addr] & ~slv_wlat;
          3'd5: slv_mem[sl_addr][3:0] <= (slv_mem[sl_addr][3:0] & ~slv_wlat[7:4]) |
                                         (slv_wlat[3:0] & slv_wlat[7:4]);
          3'd6: slv_mem[sl_addr][7:4] <= (slv_mem[sl_addr][7:4] & ~slv_wlat[7:4]) |
                                         (slv_wlat[3:0] & slv_wlat[7:4]);
          default: ;
        endcase
      end
    end
  end

  always_comb sl_rdata = (sl_op == 3'd1) ? slv_mem[sl_addr][7:4] : slv_mem[sl_addr][3:0];

  // protocol monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (sl_sel && sl_phase == 2'd2) stb_cnt <= stb_cnt + 1;
      if (prev_sel && prev_phase == 2'd0 && !(sl_sel && sl_phase == 2'd1)) proto_err <= proto_err + 1;
      if (prev_sel && prev_phase == 2'd1 && !(sl_sel && sl_phase == 2'd2)) proto_err <= proto_err + 1;
      if (sl_wdata != 8'h00 && !(sl_sel && sl_phase == 2'd1)) proto_err <= proto_err + 1;
      prev_sel   <= sl_sel;
      prev_phase <= sl_phase;
    end else begin
      prev_sel   <= 1'b0;
      prev_phase <= 2'd0;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic ref_update(input vec_t v);
    if (v.op == 2'd3) begin
      int nn = (v.size == 2'd1) ? 2 : (v.size == 2'd2) ? 4 : 1;
      int st = (v.size == 2'd3) ? 1 : 0;
      for (int j = 0; j < nn; j++) begin
        int n = st + j;
        logic [7:0] a = v.addr + 8'(n / 2);
        logic [3:0] m = v.wdata[16 + 4 * j +: 4];
        logic [3:0] d = v.wdata[4 * j +: 4];
        if (n % 2 == 0) ref_mem[a][3:0] = (ref_mem[a][3:0] & ~m) | (d & m);
        else            ref_mem[a][7:4] = (ref_mem[a][7:4] & ~m) | (d & m);
      end
    end else begin
      for (int k = 0; k < nbytes(v.size); k++) begin
        logic [7:0] a = v.addr + 8'(k);
        logic [7:0] b = v.wdata[8 * k +: 8];
        case (v.op)
          2'd1:    ref_mem[a] = ref_mem[a] | b;
          2'd2:    ref_mem[a] = ref_mem[a] & ~b;
          default: ref_mem[a] = b;
        endcase
      end
    end
  endtask

  function automatic logic [31:0] ref_read(input logic [7:0] a, input logic [1:0] sz);
    logic [31:0] r = '0;
    for (int k = 0; k < nbytes(sz); k++) r[8 * k +: 8] = ref_mem[a + 8'(k)];
    return r;
  endfunction

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic do_access(input vec_t v, output int lat, output int ntx,
                           output logic [31:0] rd);
    int s0;
    cpu_req    = 1'b1;
    cpu_we     = v.we;
    cpu_posted = v.posted;
    cpu_op     = v.op;
    cpu_size   = v.size;
    cpu_addr   = v.addr;
    cpu_wdata  = v.wdata;
    #1;
    s0  = stb_cnt;
    lat = 0;
    while (!cpu_ready && lat < 5000) begin
      @(negedge clk);
      #1;
      lat++;
    end
    rd  = cpu_rdata;
    ntx = stb_cnt - s0;
    if (v.we) ref_update(v);
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic wait_idle();
    int idle_n = 0;
    while (idle_n < 3) begin
      @(negedge clk);
      #1;
      if (!sl_sel) idle_n++;
      else         idle_n = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lat, ntx, mism;
    logic [31:0] rd;
    vec_t v;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    rst_n = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_posted = 1'b0;
    cpu_op = '0; cpu_size = '0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "ready in reset", {31'b0, cpu_ready}, 32'd0);
    chk("R1", "sel in reset", {31'b0, sl_sel}, 32'd0);
    chk("R1", "wdata in reset", {24'b0, sl_wdata}, 32'd0);
    chk("R1", "rdata in reset", cpu_rdata, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "ready after reset", {31'b0, cpu_ready}, 32'd0);
    chk("R1", "sel after reset", {31'b0, sl_sel}, 32'd0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      if (v.lat != 8'd0) wait_idle();
      do_access(v, lat, ntx, rd);
      if (v.we && v.posted)   chk("R6", "posted ack latency", lat, 32'(v.lat));
      else if (v.we)          chk("R8", "blocking write latency", lat, 32'(v.lat));
      else                    chk("R10", "read latency", lat, 32'(v.lat));
      if (v.lat != 8'd0) begin
        if (!v.we)              chk("R3", "read transaction count", ntx, (32'(v.lat) - 2) / 3);
        else if (v.op == 2'd3)  chk("R5", "masked transaction count", ntx, (32'(v.lat) - 2) / 3);
        else                    chk("R4", "direct transaction count", ntx, (32'(v.lat) - 2) / 3);
      end
      if (!v.we) chk("R3", "read data", rd, ref_read(v.addr, v.size));
    end

    // queue full: six back-to-back posted 32-bit writes
    wait_idle();
    for (int i = 0; i < 6; i++) begin
      v = '{1'b1, 1'b1, 2'd0, 2'd2, 8'h40 + 8'(4 * i), 32'h1357_9BDF ^ (32'h0101_0101 * i), 8'd0};
      do_access(v, lat, ntx, rd);
      chk("R7", "posted ack with queue full", lat, (i == 5) ? 32'd10 : 32'd0);
    end
    v = '{1'b0, 1'b0, 2'd0, 2'd2, 8'h54, 32'h0, 8'd0};
    do_access(v, lat, ntx, rd);
    chk("R9", "read behind posted writes", rd, ref_read(8'h54, 2'd2));
    v = '{1'b0, 1'b0, 2'd0, 2'd2, 8'h40, 32'h0, 8'd0};
    do_access(v, lat, ntx, rd);
    chk("R9", "read of oldest posted write", rd, ref_read(8'h40, 2'd2));

    wait_idle();
    mism = 0;
    for (int i = 0; i < 256; i++) if (slv_mem[i] !== ref_mem[i]) mism++;
    chk("R4", "slave registers vs reference (R5 masked too)", mism, 32'd0);
    chk("R2", "slave phase protocol violations", proto_err, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule